// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This unit sits on the data path between a 32-bit bus master and a memory or peripheral slave. Both sides use a simple handshake. The requester holds `valid` together with its address, direction and data until it sees `ready` for one cycle. The response (`rdata`, `err`) comes back in that same cycle.

Most transfers are forwarded unchanged. Some data accesses land in one of two 32 MB alias windows: 0x2200_0000 maps onto the 1 MB region at 0x2000_0000, and 0x4200_0000 maps onto the 1 MB region at 0x4000_0000. Each word of an alias window stands for a single bit of the backing region.

- **Alias read:** fetches the backing word and returns the selected bit.
- **Alias write:** performs a locked read-modify-write that sets or clears only that bit.

The controller is a six-state machine:

- `ST_IDLE` waits for a request and latches its decode. It branches to `ST_PASS` for ordinary traffic and to `ST_RD` for alias traffic.
- `ST_PASS` forwards the transfer and, on slave ready, moves to `ST_DONE`.
- `ST_RD` reads the backing word. From there it goes to:
  - `ST_MOD` on a successful read for an alias write;
  - `ST_DONE` for an alias read;
  - `ST_DONE` on any read error.
- `ST_MOD` spends one clock building the new word, then moves to `ST_WR`.
- `ST_WR` writes that word back and, on slave ready, moves to `ST_DONE`.
- `ST_DONE` returns the response to the master and goes back to `ST_IDLE`.

Top module: `bitband_bridge`

## Requirements
- R1: A data access whose address lies outside both alias windows reaches the slave with the same address, direction and write data. The slave's read data and error flag are returned to the master unchanged.
- R2: An alias address A in a window with alias base AB and region base RB selects backing word RB + 4*A[24:7] and bit A[6:2]. This equals the relation A = AB + 32*(byte offset) + 4*(bit within word). The windows are 0x2200_0000 onto 0x2000_0000 and 0x4200_0000 onto 0x4000_0000, and the top word of a window (for example 0x43FF_FFFC) maps to bit 31 of 0x400F_FFFC.
- R3: An alias write with write-data bit 0 equal to 1 sets the selected backing bit and leaves every other bit of the backing word unchanged.
- R4: An alias write with write-data bit 0 equal to 0 clears the selected bit. Bits 31:1 of the write data have no effect.
- R5: An alias read issues exactly one backing read and no write. It returns the selected bit in bit 0 of read data, with bits 31:1 zero.
- R6: An instruction fetch (`m_fetch`=1) to an alias address is forwarded unchanged, without remapping.
- R7: Addresses at or above the end of a 32 MB alias window (for example 0x4400_0000) are forwarded unchanged.
- R8: For an alias write, `s_lock` is high during the backing read, the modify clock and the write-back. A slave request holds its address, direction and data stable until `s_ready`.
- R9: `m_ready` stays low until the whole sequence has finished, is never high while a slave request is outstanding, and is a single-cycle pulse.
- R10: A slave error on the read phase is returned on `m_err` and no write phase is issued. A slave error on the write phase is also returned on `m_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | 1 | Master request valid, held until `m_ready` |
| m_addr | input | 32 | Master byte address |
| m_write | input | 1 | 1 = write, 0 = read |
| m_wdata | input | 32 | Master write data |
| m_fetch | input | 1 | 1 = instruction fetch, never remapped |
| m_ready | output | 1 | One-cycle completion pulse to the master |
| m_rdata | output | 32 | Read data to the master (0 for alias writes) |
| m_err | output | 1 | Error response to the master |
| s_valid | output | 1 | Slave request valid |
| s_addr | output | 32 | Slave byte address |
| s_write | output | 1 | Slave direction |
| s_wdata | output | 32 | Slave write data |
| s_lock | output | 1 | Slave bus lock across a read-modify-write |
| s_ready | input | 1 | Slave completion |
| s_rdata | input | 32 | Slave read data |
| s_err | input | 1 | Slave error response |

## Verification
The bench aims the set and clear paths at a backing word with mixed contents, so a design that overwrites the whole word, or decodes the bit from the wrong address field, corrupts neighbouring bits. It drives the first and last words of a window, a fetch into a window and an address just past a window. These expose a decoder that compares too few high bits or ignores the access type, which would remap traffic that must pass. It injects slave errors on the read phase and on the write phase. A design that issues the write after a failed read, or drops either error, shows up in the slave traffic log or in the response the scoreboard expects.

// File: rtl/bitband_pkg.sv
package bitband_pkg;
    localparam int BB_AW = 32;
    localparam int BB_DW = 32;
    localparam int BB_BW = $clog2(BB_DW);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PASS,
        ST_RD,
        ST_MOD,
        ST_WR,
        ST_DONE
    } bb_state_e;

    typedef struct packed {
        logic             hit;
        logic [BB_AW-1:0] word_addr;
        logic [BB_BW-1:0] bit_idx;
    } bb_decode_t;
endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode
    import bitband_pkg::*;
#(
    parameter int                         NWIN        = 2,
    parameter int                         SPAN_BITS   = 25,
    parameter logic [NWIN-1:0][BB_AW-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NWIN-1:0][BB_AW-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic [BB_AW-1:0] addr,
    input  logic             fetch,
    output bb_decode_t       dec
);
    localparam int LO = BB_BW + 2;

    logic [NWIN-1:0]            hit_v;
    logic [NWIN-1:0][BB_AW-1:0] word_v;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign hit_v[w]  = !fetch && (addr[BB_AW-1:SPAN_BITS] == ALIAS_BASE[w][BB_AW-1:SPAN_BITS]);
        assign word_v[w] = REGION_BASE[w] + BB_AW'({addr[SPAN_BITS-1:LO], 2'b00});
    end

    always_comb begin
        dec           = '0;
        dec.bit_idx   = addr[LO-1:2];
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (hit_v[w]) begin
                dec.hit       = 1'b1;
                dec.word_addr = word_v[w];
            end
        end
    end

    logic unused_lsb;
    assign unused_lsb = ^addr[1:0];
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
    import bitband_pkg::*;
(
    input  logic [BB_DW-1:0] word_in,
    input  logic [BB_BW-1:0] bit_idx,
    input  logic             set_bit,
    output logic [BB_DW-1:0] word_out,
    output logic             bit_val
);
    logic [BB_DW-1:0] mask;

    always_comb begin
        mask     = BB_DW'(1) << bit_idx;
        word_out = set_bit ? (word_in | mask) : (word_in & ~mask);
        bit_val  = |(word_in & mask);
    end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bitband_pkg::*;
#(
    parameter int                         NWIN        = 2,
    parameter int                         SPAN_BITS   = 25,
    parameter logic [NWIN-1:0][BB_AW-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NWIN-1:0][BB_AW-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_valid,
    input  logic [BB_AW-1:0] m_addr,
    input  logic             m_write,
    input  logic [BB_DW-1:0] m_wdata,
    input  logic             m_fetch,
    output logic             m_ready,
    output logic [BB_DW-1:0] m_rdata,
    output logic             m_err,
    output logic             s_valid,
    output logic [BB_AW-1:0] s_addr,
    output logic             s_write,
    output logic [BB_DW-1:0] s_wdata,
    output logic             s_lock,
    input  logic             s_ready,
    input  logic [BB_DW-1:0] s_rdata,
    input  logic             s_err
);
    bb_state_e        state_q, state_d;
    bb_decode_t       dec_in, dec_q;
    logic [BB_AW-1:0] addr_q;
    logic             write_q;
    logic [BB_DW-1:0] wdata_q;
    logic [BB_DW-1:0] word_q;
    logic [BB_DW-1:0] rsp_data_q;
    logic             rsp_err_q;
    logic [BB_DW-1:0] merge_in, merge_out;
    logic             merge_bit;

    bb_alias_decode #(
        .NWIN        (NWIN),
        .SPAN_BITS   (SPAN_BITS),
        .ALIAS_BASE  (ALIAS_BASE),
        .REGION_BASE (REGION_BASE)
    ) u_decode (
        .addr  (m_addr),
        .fetch (m_fetch),
        .dec   (dec_in)
    );

    assign merge_in = (state_q == ST_RD) ? s_rdata : word_q;

    bb_bit_merge u_merge (
        .word_in  (merge_in),
        .bit_idx  (dec_q.bit_idx),
        .set_bit  (wdata_q[0]),
        .word_out (merge_out),
        .bit_val  (merge_bit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (m_valid) state_d = dec_in.hit ? ST_RD : ST_PASS;
            ST_PASS: if (s_ready) state_d = ST_DONE;
            ST_RD: begin
                if (s_ready) state_d = (s_err || !write_q) ? ST_DONE : ST_MOD;
            end
            ST_MOD:  state_d = ST_WR;
            ST_WR:   if (s_ready) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q      <= '0;
            addr_q     <= '0;
            write_q    <= 1'b0;
            wdata_q    <= '0;
            word_q     <= '0;
            rsp_data_q <= '0;
            rsp_err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (m_valid) begin
                        dec_q   <= dec_in;
                        addr_q  <= m_addr;
                        write_q <= m_write;
                        wdata_q <= m_wdata;
                    end
                end
                ST_PASS: begin
                    if (s_ready) begin
                        rsp_data_q <= s_rdata;
                        rsp_err_q  <= s_err;
                    end
                end
                ST_RD: begin
                    if (s_ready) begin
                        rsp_err_q  <= s_err;
                        rsp_data_q <= (s_err || write_q) ? '0 : BB_DW'(merge_bit);
                        word_q     <= s_rdata;
                    end
                end
                ST_MOD: word_q <= merge_out;
                ST_WR: begin
                    if (s_ready) begin
                        rsp_err_q  <= s_err;
                        rsp_data_q <= '0;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        s_valid = 1'b0;
        s_addr  = addr_q;
        s_write = write_q;
        s_wdata = wdata_q;
        s_lock  = 1'b0;
        m_ready = 1'b0;
        m_rdata = rsp_data_q;
        m_err   = rsp_err_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_PASS: s_valid = 1'b1;
            ST_RD: begin
                s_valid = 1'b1;
                s_addr  = dec_q.word_addr;
                s_write = 1'b0;
                s_lock  = write_q;
            end
            ST_MOD: begin
                s_addr = dec_q.word_addr;
                s_lock = 1'b1;
            end
            ST_WR: begin
                s_valid = 1'b1;
                s_addr  = dec_q.word_addr;
                s_write = 1'b1;
                s_wdata = word_q;
                s_lock  = 1'b1;
            end
            ST_DONE: m_ready = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        m_ready,
    input logic        s_valid,
    input logic        s_ready,
    input logic        s_write,
    input logic        s_lock,
    input logic        s_err,
    input logic [31:0] s_addr,
    input logic [31:0] s_wdata
);
    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        m_ready |=> !m_ready);

    a_r9_no_ready_during_slave: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |-> !m_ready);

    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !s_ready) |=> (s_valid && $stable(s_addr) && $stable(s_write) && $stable(s_wdata)));

    a_r8_lock_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && !s_write && s_lock && !s_err) |=> s_lock);

    a_r8_locked_write_follows_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_write && s_lock) |-> $past(s_lock));

    a_r10_no_write_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && !s_write && s_lock && s_err) |=> !s_lock);
endmodule

bind bitband_bridge bitband_bridge_chk u_chk (.*);

// File: tb/bitband_bridge_tb.sv
module bitband_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_valid = 1'b0, m_write = 1'b0, m_fetch = 1'b0;
    logic [31:0] m_addr = '0, m_wdata = '0;
    logic        m_ready, m_err;
    logic [31:0] m_rdata;
    logic        s_valid, s_write, s_lock;
    logic [31:0] s_addr, s_wdata;
    logic        s_ready = 1'b0, s_err = 1'b0;
    logic [31:0] s_rdata = '0;

    always #5 clk = ~clk;

    bitband_bridge u_dut (.*);

    int n_tests = 0, n_fail = 0;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic [31:0] mem[logic [31:0]];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    bit          err_rd = 0, err_wr = 0;
    int          n_rd, n_wr, n_rdy, wcnt = 0;
    logic [31:0] rd_addr, wr_addr, slv_addr;
    bit          rd_lock, wr_lock;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // slave model
    always @(negedge clk) begin
        if (!rst_n) begin
            s_ready = 1'b0;
            wcnt    = 0;
        end else if (s_ready) begin
            s_ready = 1'b0;
        end else if (s_valid) begin
            if (wcnt < 1) wcnt++;
            else begin
                wcnt     = 0;
                s_ready  = 1'b1;
                slv_addr = s_addr;
                s_err    = (s_addr == err_addr) && (s_write ? err_wr : err_rd);
                if (s_write) begin
                    s_rdata = '0;
                    if (!s_err) mem[s_addr] = s_wdata;
                    n_wr++;
                    wr_addr = s_addr;
                    wr_lock = s_lock;
                end else begin
                    s_rdata = (!s_err && mem.exists(s_addr)) ? mem[s_addr] : '0;
                    n_rd++;
                    rd_addr = s_addr;
                    rd_lock = s_lock;
                end
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && m_ready) begin
            n_rdy++;
            if (exp_q.size() == 0) begin
                chk(0, "R9", "unexpected m_ready", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(m_rdata == e.rdata, e.tag, "m_rdata", m_rdata, e.rdata);
                chk(m_err == e.err, e.tag, "m_err", 32'(m_err), 32'(e.err));
            end
        end
    end

    task automatic do_op(input logic [31:0] a, input bit wr, input logic [31:0] d,
                         input bit f, input logic [31:0] er, input bit ee, input string tag);
        int guard;
        exp_q.push_back('{rdata: er, err: ee, tag: tag});
        n_rd = 0; n_wr = 0; n_rdy = 0;
        @(negedge clk);
        m_valid = 1'b1; m_addr = a; m_write = wr; m_wdata = d; m_fetch = f;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!m_ready && guard < 1000);
        if (guard >= 1000) chk(0, tag, "watchdog on m_ready", 32'd0, 32'd1);
        m_valid = 1'b0;
        @(negedge clk);
        chk(n_rdy == 1, "R9", "ready pulses per op", 32'(n_rdy), 32'd1);
    endtask

    initial begin
        #100000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!m_ready && !s_valid && !s_lock, "R9", "reset outputs idle",
            {29'd0, m_ready, s_valid, s_lock}, 32'd0);
        rst_n = 1'b1;

        // R1 pass-through
        do_op(32'h1000_0010, 1, 32'hA5A5_5A5A, 0, 32'd0, 0, "R1");
        chk(mem[32'h1000_0010] == 32'hA5A5_5A5A, "R1", "pass write data", mem[32'h1000_0010], 32'hA5A5_5A5A);
        chk(n_wr == 1 && wr_addr == 32'h1000_0010 && !wr_lock, "R1", "pass write addr", wr_addr, 32'h1000_0010);
        do_op(32'h1000_0010, 0, 32'd0, 0, 32'hA5A5_5A5A, 0, "R1");

        // R3 set bit 2 of 0x4000_0004 via 0x4200_0088
        mem[32'h4000_0004] = 32'h1234_5670;
        do_op(32'h4200_0088, 1, 32'h0000_0001, 0, 32'd0, 0, "R3");
        chk(mem[32'h4000_0004] == 32'h1234_5674, "R3", "set bit", mem[32'h4000_0004], 32'h1234_5674);
        chk(rd_addr == 32'h4000_0004 && wr_addr == 32'h4000_0004, "R2", "backing addr", rd_addr, 32'h4000_0004);
        chk(rd_lock && wr_lock && n_rd == 1 && n_wr == 1, "R8", "locked rmw",
            {rd_lock, wr_lock, 30'(n_rd + n_wr)}, {2'b11, 30'd2});

        // R4 clear bit 4, upper data bits ignored
        do_op(32'h4200_0090, 1, 32'hFFFF_FFFE, 0, 32'd0, 0, "R4");
        chk(mem[32'h4000_0004] == 32'h1234_5664, "R4", "clear bit", mem[32'h4000_0004], 32'h1234_5664);

        // R5 alias reads
        do_op(32'h4200_0088, 0, 32'd0, 0, 32'd1, 0, "R5");
        chk(n_rd == 1 && n_wr == 0 && !rd_lock, "R5", "one read no write", 32'(n_wr), 32'd0);
        do_op(32'h4200_008C, 0, 32'd0, 0, 32'd0, 0, "R5");
        mem[32'h2000_0100] = 32'h8000_0000;
        do_op(32'h2200_207C, 0, 32'd0, 0, 32'd1, 0, "R2");

        // R2 first window, write
        mem[32'h2000_0010] = 32'h0;
        do_op(32'h2200_0200, 1, 32'd1, 0, 32'd0, 0, "R2");
        chk(mem[32'h2000_0010] == 32'd1, "R2", "window0 set", mem[32'h2000_0010], 32'd1);

        // R2 top of window
        mem[32'h400F_FFFC] = 32'h0;
        do_op(32'h43FF_FFFC, 1, 32'd1, 0, 32'd0, 0, "R2");
        chk(mem[32'h400F_FFFC] == 32'h8000_0000, "R2", "top word bit31", mem[32'h400F_FFFC], 32'h8000_0000);

        // R6 fetch passes through
        mem[32'h4200_0088] = 32'hDEAD_BEEF;
        do_op(32'h4200_0088, 0, 32'd0, 1, 32'hDEAD_BEEF, 0, "R6");
        chk(rd_addr == 32'h4200_0088, "R6", "fetch addr", rd_addr, 32'h4200_0088);

        // R7 beyond window
        do_op(32'h4400_0000, 1, 32'd5, 0, 32'd0, 0, "R7");
        chk(wr_addr == 32'h4400_0000 && n_rd == 0 && mem[32'h4400_0000] == 32'd5, "R7",
            "no remap", wr_addr, 32'h4400_0000);

        // R10 read-phase error
        mem[32'h4000_0008] = 32'h0;
        err_addr = 32'h4000_0008; err_rd = 1; err_wr = 0;
        do_op(32'h4200_0100, 1, 32'd1, 0, 32'd0, 1, "R10");
        chk(n_wr == 0 && mem[32'h4000_0008] == 32'h0, "R10", "write skipped", 32'(n_wr), 32'd0);

        // R10 write-phase error
        err_rd = 0; err_wr = 1;
        do_op(32'h4200_0100, 1, 32'd1, 0, 32'd0, 1, "R10");
        chk(n_rd == 1 && n_wr == 1, "R10", "write attempted", 32'(n_wr), 32'd1);
        err_addr = 32'hFFFF_FFFF; err_wr = 0;

        chk(exp_q.size() == 0, "R9", "scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule